// File: doc/BRIEF.md
# Staged Fractional Clock-Enable Divider with Source Selector

This block derives a clock-enable pulse train from one of several source enables. All logic runs on one clock, and each source is a per-cycle enable on that clock. A selector picks the source. An integer pre-divider thins the selected pulses. A downstream divider with fractional bits then divides the stream further, using a phase accumulator. Over time, the average spacing of the output pulses equals the programmed fractional divisor.

Software programs the block through a small register port. Values written to the selector and divider fields are only staged. They reach the datapath when a trigger bit is written with 1:
- The main trigger moves the downstream divider.
- The pre-trigger moves the selector and the pre-divider.

A trigger bit reads 1 while its change is pending. The change is applied at the end of the current output period, and the bit clears on that same cycle.

While the gate input is low:
- No pulses are produced.
- Field writes are dropped.
- A pending trigger clears without applying anything.

A selector code with no source behind it silences the output. Because there is then no period to wait for, a pending change applies on the next cycle.

Top module: `fracdiv_clkgen`

## Requirements
- R1: After reset the staged selector field reads all ones (code 3, an undefined source), both divider fields read 0, both trigger bits read 0, and no pulses appear.
- R2: Selector code v below the source count makes the output count only the pulses of `src_en[v]`; pulses on other sources have no effect.
- R3: A selector code equal to or above the source count produces no output pulses.
- R4: The pre-divider field (address 0, bits 10:8) holds the ratio minus one, so every output spacing scales by field+1 cycles of the selected source.
- R5: The divider field (address 1, bits 5:0) has 2 fractional low bits. The scaled divisor is S = field + 4. Output spacings are floor(S/4) or ceil(S/4) pre-divider pulses, and any 4 consecutive spacings add up to exactly S.
- R6: Writing 1 to a trigger bit at address 2 (bit 0 main, bit 1 pre) sets that bit, and it reads 1 while the change is pending.
- R7: With a valid source selected, a pending change applies on a cycle that emits an output pulse, and its trigger bit reads 0 from that cycle on. The divider state restarts, so the first new pulse follows after ceil(S/4)·(pre+1) source pulses.
- R8: The main trigger applies only the downstream divider. The pre-trigger applies only the selector and pre-divider.
- R9: A field write without a trigger does not change the output, and it reads back as the staged value.
- R10: While `gate_en` is low:
  - no pulses appear;
  - field writes are ignored;
  - a trigger bit clears one cycle after being set, and the active settings stay unchanged.
- R11: When the active selector code is undefined, a pending change applies on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | Clock gate: 1 runs the divider and accepts field writes |
| src_en | input | 3 | Per-source input enables |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 selector/pre-divider, 1 divider, 2 triggers) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| clk_en_out | output | 1 | Output enable pulse, one cycle wide |

## Verification
The bench sweeps every divider code for three pre-divider ratios, rotating the selected source each time. For each setting it checks the restart spacing, the floor/ceiling alternation and the exact total over four spacings.
- A design that misplaced the minus-one offset on the fractional bits would drift on the total.
- One that applied changes mid-period would break the coincidence of the trigger clearing with an output pulse.

Directed cases check the split between the two triggers, staging without a trigger, and writes and triggers issued while gated. They also check the undefined selector code, where a design waiting for a pulse would leave the trigger stuck at 1.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int ADDR_W   = 2;
  localparam int PRE_LSB  = 8;
  localparam int TRIG_MAIN = 0;
  localparam int TRIG_PRE  = 1;
  localparam int N_TRIG    = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_DIV  = 2'd1,
    ADDR_TRIG = 2'd2,
    ADDR_NONE = 2'd3
  } fdiv_addr_e;
endpackage

// File: rtl/fdiv_regs.sv
module fdiv_regs
  import fdiv_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int PRE_W = 3,
  parameter int DIV_W = 6,
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              boundary,
  output logic [SEL_W-1:0]  act_sel,
  output logic [PRE_W-1:0]  act_pre,
  output logic [DIV_W-1:0]  act_div,
  output logic [SEL_W-1:0]  stg_sel,
  output logic [DIV_W-1:0]  stg_div,
  output logic [N_TRIG-1:0] busy,
  output logic              restart
);
  logic [SEL_W-1:0]  stg_sel_q, stg_sel_d, act_sel_q, act_sel_d;
  logic [PRE_W-1:0]  stg_pre_q, stg_pre_d, act_pre_q, act_pre_d;
  logic [DIV_W-1:0]  stg_div_q, stg_div_d, act_div_q, act_div_d;
  logic [N_TRIG-1:0] busy_q, busy_d, go;
  logic              wr_cfg, wr_div, wr_trig, apply_ok;
  logic [REG_W-1:0]  unused_wr;

  assign unused_wr = wr_data;

  always_comb begin
    wr_cfg   = wr_en && gate_en && (fdiv_addr_e'(wr_addr) == ADDR_CFG);
    wr_div   = wr_en && gate_en && (fdiv_addr_e'(wr_addr) == ADDR_DIV);
    wr_trig  = wr_en && (fdiv_addr_e'(wr_addr) == ADDR_TRIG);
    apply_ok = gate_en && boundary;
  end

  always_comb begin
    stg_sel_d = wr_cfg ? wr_data[SEL_W-1:0]         : stg_sel_q;
    stg_pre_d = wr_cfg ? wr_data[PRE_LSB +: PRE_W]  : stg_pre_q;
    stg_div_d = wr_div ? wr_data[DIV_W-1:0]         : stg_div_q;
  end

  for (genvar b = 0; b < N_TRIG; b++) begin : g_trig
    always_comb begin
      go[b]     = busy_q[b] && apply_ok;
      busy_d[b] = (busy_q[b] && gate_en && !boundary) || (wr_trig && wr_data[b]);
    end
  end

  always_comb begin
    act_div_d = go[TRIG_MAIN] ? stg_div_q : act_div_q;
    act_sel_d = go[TRIG_PRE]  ? stg_sel_q : act_sel_q;
    act_pre_d = go[TRIG_PRE]  ? stg_pre_q : act_pre_q;
    restart   = |go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_sel_q <= '1;
      act_sel_q <= '1;
      stg_pre_q <= '0;
      act_pre_q <= '0;
      stg_div_q <= '0;
      act_div_q <= '0;
      busy_q    <= '0;
    end else begin
      stg_sel_q <= stg_sel_d;
      act_sel_q <= act_sel_d;
      stg_pre_q <= stg_pre_d;
      act_pre_q <= act_pre_d;
      stg_div_q <= stg_div_d;
      act_div_q <= act_div_d;
      busy_q    <= busy_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (fdiv_addr_e'(rd_addr))
      ADDR_CFG: begin
        rd_data[SEL_W-1:0]        = stg_sel_q;
        rd_data[PRE_LSB +: PRE_W] = stg_pre_q;
      end
      ADDR_DIV:  rd_data[DIV_W-1:0]  = stg_div_q;
      ADDR_TRIG: rd_data[N_TRIG-1:0] = busy_q;
      default:   rd_data = '0;
    endcase
  end

  assign act_sel = act_sel_q;
  assign act_pre = act_pre_q;
  assign act_div = act_div_q;
  assign stg_sel = stg_sel_q;
  assign stg_div = stg_div_q;
  assign busy    = busy_q;
endmodule

// File: rtl/fdiv_presel.sv
module fdiv_presel #(
  parameter int NSRC  = 3,
  parameter int SEL_W = 2,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en,
  input  logic [NSRC-1:0]  src_en,
  input  logic [SEL_W-1:0] act_sel,
  input  logic [PRE_W-1:0] act_pre,
  input  logic             restart,
  output logic             sel_valid,
  output logic             pre_pulse
);
  logic             src_hit, src_pulse;
  logic [PRE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    src_hit = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (act_sel == SEL_W'(i)) src_hit = src_en[i];
    end
    sel_valid = (int'(act_sel) < NSRC);
    src_pulse = sel_valid && src_hit && gate_en;
    pre_pulse = src_pulse && (cnt_q == act_pre);
  end

  always_comb begin
    if (restart)        cnt_d = '0;
    else if (pre_pulse) cnt_d = '0;
    else if (src_pulse) cnt_d = cnt_q + PRE_W'(1);
    else                cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fdiv_frac.sv
module fdiv_frac #(
  parameter int DIV_W  = 6,
  parameter int FRAC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_pulse,
  input  logic [DIV_W-1:0] act_div,
  input  logic             restart,
  output logic             fire
);
  localparam int ACC_W = DIV_W + 1;
  localparam int ONE   = 1 << FRAC_W;

  logic [ACC_W-1:0] acc_q, acc_d, scaled, sum;

  always_comb begin
    scaled = {1'b0, act_div} + ACC_W'(ONE);
    sum    = acc_q + ACC_W'(ONE);
    fire   = pre_pulse && (sum >= scaled);
    if (restart)        acc_d = '0;
    else if (fire)      acc_d = sum - scaled;
    else if (pre_pulse) acc_d = sum;
    else                acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/fracdiv_clkgen.sv
module fracdiv_clkgen
  import fdiv_pkg::*;
#(
  parameter int NSRC   = 3,
  parameter int SEL_W  = 2,
  parameter int PRE_W  = 3,
  parameter int DIV_W  = 6,
  parameter int FRAC_W = 2,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic [NSRC-1:0]   src_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              clk_en_out
);
  logic [1:0]        rst_sync_q;
  logic              rst_ns;
  logic [SEL_W-1:0]  act_sel, stg_sel;
  logic [PRE_W-1:0]  act_pre;
  logic [DIV_W-1:0]  act_div, stg_div;
  logic [N_TRIG-1:0] busy;
  logic              restart, sel_valid, pre_pulse, fire, boundary, out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  assign boundary = fire || !sel_valid;

  fdiv_regs #(
    .SEL_W(SEL_W), .PRE_W(PRE_W), .DIV_W(DIV_W), .REG_W(REG_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_ns), .gate_en(gate_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .boundary(boundary),
    .act_sel(act_sel), .act_pre(act_pre), .act_div(act_div),
    .stg_sel(stg_sel), .stg_div(stg_div), .busy(busy), .restart(restart)
  );

  fdiv_presel #(
    .NSRC(NSRC), .SEL_W(SEL_W), .PRE_W(PRE_W)
  ) u_presel (
    .clk(clk), .rst_n(rst_ns), .gate_en(gate_en), .src_en(src_en),
    .act_sel(act_sel), .act_pre(act_pre), .restart(restart),
    .sel_valid(sel_valid), .pre_pulse(pre_pulse)
  );

  fdiv_frac #(
    .DIV_W(DIV_W), .FRAC_W(FRAC_W)
  ) u_frac (
    .clk(clk), .rst_n(rst_ns), .pre_pulse(pre_pulse),
    .act_div(act_div), .restart(restart), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) out_q <= 1'b0;
    else         out_q <= fire;
  end
  assign clk_en_out = out_q;
endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk
  import fdiv_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int DIV_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gate_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              clk_en_out,
  input logic [N_TRIG-1:0] busy,
  input logic [DIV_W-1:0]  act_div,
  input logic [SEL_W-1:0]  stg_sel,
  input logic [DIV_W-1:0]  stg_div,
  input logic              sel_valid
);
  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> !clk_en_out); // R10

  AST_GATED_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> ($stable(stg_div) && $stable(stg_sel))); // R10

  AST_GATED_TRIG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en && !(wr_en && wr_addr == ADDR_TRIG)) |=> (busy == '0)); // R10

  AST_BAD_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |=> !clk_en_out); // R3

  AST_COMMIT_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy[TRIG_MAIN]) && $past(gate_en) && $past(sel_valid)) |-> clk_en_out); // R7

  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy[TRIG_MAIN]) |-> $stable(act_div)); // R9
endmodule

bind fracdiv_clkgen fdiv_chk #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_ns), .gate_en(gate_en), .wr_en(wr_en),
  .wr_addr(wr_addr), .clk_en_out(clk_en_out), .busy(busy),
  .act_div(act_div), .stg_sel(stg_sel), .stg_div(stg_div),
  .sel_valid(sel_valid)
);

// File: tb/tb_fracdiv_clkgen.sv
module tb_fracdiv_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 3;

  logic        clk = 1'b0;
  logic        rst_n, gate_en, wr_en;
  logic [2:0]  src_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        clk_en_out;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  int tq[0:5];

  fracdiv_clkgen dut (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .src_en(src_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .clk_en_out(clk_en_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 2'(a);
    #1;
    v = int'(rd_data);
  endtask

  task automatic wait_commit(input int mask, input bit want_pulse, output int t0);
    int v;
    bit done;
    done = 1'b0;
    for (int i = 0; i < 3000 && !done; i++) begin
      @(negedge clk);
      rd(2, v);
      if ((v & mask) == 0) begin
        done = 1'b1;
        if (want_pulse) chk("R7 trigger clears with a pulse", int'(clk_en_out), 1);
      end
    end
    t0 = cyc;
    if (!done) chk("R7 trigger never cleared", 0, 1);
  endtask

  task automatic measure(input int n);
    for (int k = 1; k <= n; k++) begin
      bit got;
      got = 1'b0;
      for (int i = 0; i < 2000 && !got; i++) begin
        @(negedge clk);
        #1;
        if (clk_en_out) begin
          got = 1'b1;
          tq[k] = cyc;
        end
      end
      if (!got) begin
        chk("R2 output pulse missing", 0, 1);
        tq[k] = cyc;
      end
    end
  endtask

  task automatic count_pulses(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      if (clk_en_out) c++;
    end
  endtask

  task automatic check_gaps(input int t0, input int s, input int pv,
                            input bit first, input string req);
    int lo, hi;
    lo = (s / 4) * pv;
    hi = ((s + 3) / 4) * pv;
    if (first) chk({req, " first spacing after restart"}, tq[1] - t0, hi);
    for (int k = 2; k <= 5; k++) begin
      int g;
      g = tq[k] - tq[k-1];
      n_run++;
      if (g != lo && g != hi) begin
        n_fail++;
        $display("FAIL R5 spacing: actual %0d expected %0d or %0d", g, lo, hi);
      end
    end
    chk({req, " four-spacing total"}, tq[5] - tq[1], s * pv);
  endtask

  task automatic cfg_run(input int sel, input int p, input int d, input bit first);
    int t0;
    src_en = '1;
    wr(0, (p << 8) | sel);
    wr(1, d);
    wr(2, 3);
    wait_commit(3, first, t0);
    src_en = 3'(1 << sel);
    measure(5);
    check_gaps(t0, d + 4, p + 1, first, "R4 R7");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int v, c, t0;
    rst_n = 1'b0; gate_en = 1'b1; src_en = '1;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 selector reset", v, 3);
    rd(1, v); chk("R1 divider reset", v, 0);
    rd(2, v); chk("R1 trigger reset", v, 0);
    count_pulses(20, c); chk("R1 no pulses after reset", c, 0);

    // R11 commit from undefined selector happens next cycle
    wr(0, 0); wr(1, 0); wr(2, 3);
    @(negedge clk); rd(2, v); chk("R11 commit from idle", v & 3, 0);
    src_en = 3'b001;
    measure(5);
    check_gaps(0, 4, 1, 1'b0, "R5");

    // R4 R5 R7 sweep
    for (int p = 0; p < 3; p++) begin
      for (int d = 0; d < 64; d++) begin
        cfg_run((d + p) % NSRC, p, d, 1'b1);
      end
    end

    // R6 R8 main trigger applies divider only
    cfg_run(0, 1, 10, 1'b1);
    wr(1, 2); wr(2, 1);
    rd(2, v); chk("R6 main trigger busy", v & 3, 1);
    wait_commit(1, 1'b1, t0);
    measure(5);
    check_gaps(t0, 6, 2, 1'b1, "R8 main keeps pre-divider");

    // R8 pre trigger applies pre-divider only
    wr(0, 0); wr(1, 6); wr(2, 2);
    rd(2, v); chk("R6 pre trigger busy", v & 3, 2);
    wait_commit(2, 1'b1, t0);
    measure(5);
    check_gaps(t0, 6, 1, 1'b1, "R8 pre keeps divider");

    // R9 staging without trigger
    rd(1, v); chk("R9 staged readback", v, 6);
    wr(1, 20);
    rd(1, v); chk("R9 staged readback", v, 20);
    measure(5);
    check_gaps(0, 6, 1, 1'b0, "R9 output unchanged");

    // R10 gated behaviour
    @(negedge clk); gate_en = 1'b0;
    count_pulses(40, c); chk("R10 gated silent", c, 0);
    wr(1, 33); rd(1, v); chk("R10 gated divider write dropped", v, 20);
    wr(0, 1);  rd(0, v); chk("R10 gated selector write dropped", v, 0);
    wr(2, 3);
    @(negedge clk); rd(2, v); chk("R10 gated trigger clears", v & 3, 0);
    gate_en = 1'b1;
    measure(5);
    check_gaps(0, 6, 1, 1'b0, "R10 settings unchanged");

    // R3 undefined selector
    src_en = '1;
    wr(0, 3); wr(2, 2);
    wait_commit(2, 1'b1, t0);
    count_pulses(50, c); chk("R3 undefined selector silent", c, 0);

    // R11 leave undefined selector
    wr(0, 2); wr(2, 2);
    @(negedge clk); rd(2, v); chk("R11 commit from idle", v & 3, 0);
    measure(5);
    check_gaps(0, 6, 1, 1'b0, "R2 source 2");

    // R2 other sources ignored
    src_en = 3'b011;
    @(negedge clk);
    count_pulses(40, c); chk("R2 unselected sources ignored", c, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule